// File: doc/BRIEF.md
# Power Mode and Wake-up Controller

This block holds the 8-bit power-control register of a small 8-bit microcontroller and runs the sequencer that acts on it. Software writes the whole byte through a simple special-function-register port. One bit asks for idle and one bit asks for power-down. The register also holds a wake-exit select, a power-off flag, two general-purpose flags, and two mode bits that the serial unit uses. In idle the block withholds the CPU clock but keeps the oscillator running. In power-down it stops the oscillator entirely.

A wake request ends power-down. A wake request is an enabled interrupt, or the external hold line going high. The oscillator then restarts, and the block keeps the core in reset with its clock gated until the restart completes. With the exit select clear, a start-up counter times the restart: it runs for a fixed number of cycles, and the number is a parameter. With the exit select set, the restart lasts for as long as the external hold line stays high. The power-off flag lets firmware tell the two kinds of reset apart. A power-on (cold) reset sets the flag. A pin or brown-out (warm) reset leaves it alone.

Top module: `pmu_ctrl`

## Requirements
- R1: While `cold_rst` is high at a clock edge, the register becomes 0x10 in the following cycle: bit 4 is 1 and every other bit is 0. The block is then running, with `osc_en`=1, `cpu_clk_en`=1 and `core_rst`=0.
- R2: A warm reset (`warm_rst` high and `cold_rst` low at an edge) clears every register bit except bit 4. Bit 4 keeps its value. The block returns to running.
- R3: In the running state, a write stores the whole byte, and reading the register returns it. Bit 7 drives `baud_dbl`, bit 6 drives `fe_view_sel` and bit 5 drives `pd_exit_ext`. Bits 4, 3 and 2 are plain storage that software can set and clear.
- R4: A running write with bit 0 = 1 and bit 1 = 0 enters idle in the next cycle: `cpu_clk_en`=0 and `osc_en`=1.
- R5: In idle, `irq_wake` high at an edge returns the block to running in the next cycle and clears bit 0.
- R6: A running write with bit 1 = 1 enters power-down in the next cycle, even if bit 0 is also 1: `osc_en`=0 and `cpu_clk_en`=0. Power-down persists while no wake request is present.
- R7: In power-down, `irq_wake` or `wake_hold` high at an edge starts the restart in the next cycle: `osc_en`=1, `core_rst`=1, `cpu_clk_en`=0.
- R8: With bit 5 = 0, `core_rst` stays high for exactly STARTUP_CYC cycles (default 16). The block then runs again with bits 1 and 0 cleared.
- R9: With bit 5 = 1, the restart lasts while `wake_hold` is high. The block runs in the cycle after the first edge at which `wake_hold` is low, with bits 1 and 0 cleared.
- R10: Writes in any state other than running have no effect. A warm reset in the same cycle as a write wins, and bit 4 keeps its value from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| cold_rst | input | 1 | Power-on reset, synchronous, active high |
| warm_rst | input | 1 | Pin or brown-out reset, synchronous, active high |
| sfr_we | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Current register contents |
| irq_wake | input | 1 | An enabled interrupt is pending |
| wake_hold | input | 1 | External wake/hold line |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| core_rst | output | 1 | Internal reset held during restart |
| baud_dbl | output | 1 | Serial baud-doubling mode bit |
| fe_view_sel | output | 1 | Serial frame-error view select |
| pd_exit_ext | output | 1 | 1 = external exit from power-down, 0 = timed exit |

## Verification
Two events can land in the same cycle: a software write and a warm reset. The bench drives both in one cycle. The write data has every bit set and the power-off flag was already clear, so the reset must win and the flag must stay 0. The bench judges this by the next read of the register. A second collision comes from writing both request bits in one byte. The bench expects power-down to take priority: the oscillator must stop, and a later wake must run the restart sequence rather than return straight from idle.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    typedef enum logic [1:0] {
        PM_RUN     = 2'd0,
        PM_IDLE    = 2'd1,
        PM_DOWN    = 2'd2,
        PM_RESTART = 2'd3
    } pm_state_e;

    // Field order follows the bit positions the CPU decodes
    typedef struct packed {
        logic       baud_dbl;   // bit 7
        logic       fe_sel;     // bit 6
        logic       exit_ext;   // bit 5
        logic       pof;        // bit 4
        logic [1:0] gflag;      // bits 3:2
        logic       pd_req;     // bit 1
        logic       idl_req;    // bit 0
    } pctl_reg_t;

    localparam int PCTL_W  = 8;
    localparam int BIT_PD  = 1;
    localparam int BIT_IDL = 0;

    function automatic pctl_reg_t pctl_reset(input logic keep_pof);
        pctl_reg_t r;
        r     = '0;
        r.pof = keep_pof;
        return r;
    endfunction

endpackage

// File: rtl/pmu_startup_cnt.sv
module pmu_startup_cnt #(
    parameter int STARTUP_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (STARTUP_CYC < 2) ? 1 : $clog2(STARTUP_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STARTUP_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);

    // R8: the count never runs past its terminal value
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= LAST));

    // R8: the count restarts from zero whenever the timed restart begins
    assert_cnt_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (!run) |=> (cnt == '0));

endmodule

// File: rtl/pmu_regfile.sv
module pmu_regfile
    import pmu_pkg::*;
(
    input  logic              clk,
    input  logic              cold_rst,
    input  logic              warm_rst,
    input  logic              wr_ok,
    input  logic [PCTL_W-1:0] wdata,
    input  logic              clr_pd,
    input  logic              clr_idl,
    output pctl_reg_t         ctl
);
    always_ff @(posedge clk) begin
        if (cold_rst) begin
            ctl <= pctl_reset(1'b1);
        end else if (warm_rst) begin
            ctl <= pctl_reset(ctl.pof);
        end else if (wr_ok) begin
            ctl <= pctl_reg_t'(wdata);
        end else if (clr_pd) begin
            ctl.pd_req  <= 1'b0;
            ctl.idl_req <= 1'b0;
        end else if (clr_idl) begin
            ctl.idl_req <= 1'b0;
        end
    end

    // R2: a warm reset leaves the power-off flag alone
    assert_pof_warm_R2: assert property (@(posedge clk) disable iff (cold_rst)
        warm_rst |=> (ctl.pof == $past(ctl.pof)));

    // R8 / R9: leaving power-down clears both request bits
    assert_pd_clear_R8: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        clr_pd |=> (!ctl.pd_req && !ctl.idl_req));

    // R10: no write and no clear means the register holds
    assert_hold_R10: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        (!wr_ok && !clr_pd && !clr_idl) |=> $stable(ctl));

endmodule

// File: rtl/pmu_seq.sv
module pmu_seq
    import pmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sfr_we,
    input  logic [PCTL_W-1:0] sfr_wdata,
    input  logic              irq_wake,
    input  logic              wake_hold,
    input  logic              exit_ext,
    input  logic              timer_done,
    output logic              wr_ok,
    output logic              timer_run,
    output logic              clr_pd,
    output logic              clr_idl,
    output logic              osc_en,
    output logic              cpu_clk_en,
    output logic              core_rst
);
    pm_state_e state, state_nx;
    logic      restart_done;

    assign wr_ok        = sfr_we && (state == PM_RUN);
    assign timer_run    = (state == PM_RESTART) && !exit_ext;
    assign restart_done = exit_ext ? !wake_hold : timer_done;
    assign clr_pd       = (state == PM_RESTART) && restart_done;
    assign clr_idl      = (state == PM_IDLE) && irq_wake;

    always_comb begin
        state_nx = state;
        unique case (state)
            PM_RUN: begin
                if (wr_ok && sfr_wdata[BIT_PD])       state_nx = PM_DOWN;
                else if (wr_ok && sfr_wdata[BIT_IDL]) state_nx = PM_IDLE;
            end
            PM_IDLE:    if (irq_wake)              state_nx = PM_RUN;
            PM_DOWN:    if (irq_wake || wake_hold) state_nx = PM_RESTART;
            PM_RESTART: if (restart_done)          state_nx = PM_RUN;
            default:                               state_nx = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PM_RUN;
        else     state <= state_nx;
    end

    assign osc_en     = (state != PM_DOWN);
    assign cpu_clk_en = (state == PM_RUN);
    assign core_rst   = (state == PM_RESTART);

    // R6: a power-down request stops the oscillator next cycle
    assert_pd_entry_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && sfr_wdata[BIT_PD]) |=> !osc_en);

    // R4: an idle-only request gates the CPU but keeps the oscillator
    assert_idle_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && !sfr_wdata[BIT_PD] && sfr_wdata[BIT_IDL]) |=> (!cpu_clk_en && osc_en));

    // R5: an interrupt in idle resumes the CPU clock
    assert_idle_exit_R5: assert property (@(posedge clk) disable iff (rst)
        (state == PM_IDLE && irq_wake) |=> cpu_clk_en);

    // R7: a wake in power-down starts the restart with the core in reset
    assert_wake_R7: assert property (@(posedge clk) disable iff (rst)
        (state == PM_DOWN && (irq_wake || wake_hold)) |=> (core_rst && osc_en && !cpu_clk_en));

    // R9: external mode keeps the restart going while the hold line is high
    assert_ext_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (core_rst && exit_ext && wake_hold) |=> core_rst);

endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
    import pmu_pkg::*;
#(
    parameter int STARTUP_CYC = 16
) (
    input  logic       clk,
    input  logic       cold_rst,
    input  logic       warm_rst,
    input  logic       sfr_we,
    input  logic [7:0] sfr_wdata,
    output logic [7:0] sfr_rdata,
    input  logic       irq_wake,
    input  logic       wake_hold,
    output logic       osc_en,
    output logic       cpu_clk_en,
    output logic       core_rst,
    output logic       baud_dbl,
    output logic       fe_view_sel,
    output logic       pd_exit_ext
);
    pctl_reg_t ctl;
    logic      any_rst;
    logic      wr_ok, timer_run, timer_done, clr_pd, clr_idl;

    assign any_rst = cold_rst || warm_rst;

    pmu_regfile u_regfile (
        .clk      (clk),
        .cold_rst (cold_rst),
        .warm_rst (warm_rst),
        .wr_ok    (wr_ok),
        .wdata    (sfr_wdata),
        .clr_pd   (clr_pd),
        .clr_idl  (clr_idl),
        .ctl      (ctl)
    );

    pmu_seq u_seq (
        .clk        (clk),
        .rst        (any_rst),
        .sfr_we     (sfr_we),
        .sfr_wdata  (sfr_wdata),
        .irq_wake   (irq_wake),
        .wake_hold  (wake_hold),
        .exit_ext   (ctl.exit_ext),
        .timer_done (timer_done),
        .wr_ok      (wr_ok),
        .timer_run  (timer_run),
        .clr_pd     (clr_pd),
        .clr_idl    (clr_idl),
        .osc_en     (osc_en),
        .cpu_clk_en (cpu_clk_en),
        .core_rst   (core_rst)
    );

    pmu_startup_cnt #(.STARTUP_CYC(STARTUP_CYC)) u_startup (
        .clk  (clk),
        .rst  (any_rst),
        .run  (timer_run),
        .done (timer_done)
    );

    assign sfr_rdata   = ctl;
    assign baud_dbl    = ctl.baud_dbl;
    assign fe_view_sel = ctl.fe_sel;
    assign pd_exit_ext = ctl.exit_ext;

    // R1: after a cold reset the block runs with the power-off flag set
    assert_cold_R1: assert property (@(posedge clk)
        cold_rst |=> (sfr_rdata == 8'h10 && cpu_clk_en && !core_rst));

endmodule

// File: tb/pmu_ctrl_bench.sv
`timescale 1ns/1ps
module pmu_ctrl_bench;

    logic       clk = 1'b0;
    logic       cold_rst = 1'b1, warm_rst = 1'b0, sfr_we = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic       irq_wake = 1'b0, wake_hold = 1'b0;
    logic [7:0] sfr_rdata;
    logic       osc_en, cpu_clk_en, core_rst, baud_dbl, fe_view_sel, pd_exit_ext;

    always #2 clk = ~clk;

    pmu_ctrl #(.STARTUP_CYC(16)) u_pmu_ctrl (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .sfr_we(sfr_we), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .irq_wake(irq_wake), .wake_hold(wake_hold),
        .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .core_rst(core_rst),
        .baud_dbl(baud_dbl), .fe_view_sel(fe_view_sel), .pd_exit_ext(pd_exit_ext)
    );

    typedef struct {
        string      tag;
        logic [7:0] rd;
        logic       osc, cpu, crst;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    // Drive inputs away from the edge, then wait past the next edge
    task automatic cyc(input logic we, input logic [7:0] wd, input logic irq,
                       input logic hold, input logic warm, input logic cold);
        @(negedge clk);
        sfr_we = we; sfr_wdata = wd; irq_wake = irq;
        wake_hold = hold; warm_rst = warm; cold_rst = cold;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_state(input string tag, input logic [7:0] rd,
                                input logic osc, input logic cpu, input logic crst);
        exp_t e;
        e.tag = tag; e.rd = rd; e.osc = osc; e.cpu = cpu; e.crst = crst;
        q.push_back(e);
    endtask

    // Monitor: compare queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                logic [10:0] act, exp;
                e   = q.pop_front();
                act = {sfr_rdata, osc_en, cpu_clk_en, core_rst};
                exp = {e.rd, e.osc, e.cpu, e.crst};
                checks++;
                if (act !== exp || {baud_dbl, fe_view_sel, pd_exit_ext} !== e.rd[7:5]) begin
                    errors++;
                    $display("FAIL %s: actual rd=%h osc=%b cpu=%b rst=%b modes=%b expected rd=%h osc=%b cpu=%b rst=%b",
                             e.tag, sfr_rdata, osc_en, cpu_clk_en, core_rst,
                             {baud_dbl, fe_view_sel, pd_exit_ext}, e.rd, e.osc, e.cpu, e.crst);
                end
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(0, 8'h00, 0, 0, 0, 1);
        cyc(0, 8'h00, 0, 0, 0, 1);
        expect_state("R1 cold reset", 8'h10, 1, 1, 0);

        cyc(1, 8'hEC, 0, 0, 0, 0);
        expect_state("R3 write modes+flags", 8'hEC, 1, 1, 0);
        cyc(1, 8'h1C, 0, 0, 0, 0);
        expect_state("R3 set pof", 8'h1C, 1, 1, 0);
        cyc(0, 8'h00, 0, 0, 1, 0);
        expect_state("R2 warm keeps pof=1", 8'h10, 1, 1, 0);
        cyc(1, 8'h0C, 0, 0, 0, 0);
        expect_state("R3 clear pof", 8'h0C, 1, 1, 0);
        cyc(0, 8'h00, 0, 0, 1, 0);
        expect_state("R2 warm keeps pof=0", 8'h00, 1, 1, 0);
        cyc(1, 8'hFF, 0, 0, 1, 0);
        expect_state("R10 warm beats write", 8'h00, 1, 1, 0);

        // Idle
        cyc(1, 8'h01, 0, 0, 0, 0);
        expect_state("R4 idle entry", 8'h01, 1, 0, 0);
        cyc(1, 8'h02, 0, 0, 0, 0);
        expect_state("R10 write in idle ignored", 8'h01, 1, 0, 0);
        cyc(0, 8'h00, 1, 0, 0, 0);
        expect_state("R5 idle exit", 8'h00, 1, 1, 0);

        // Power-down, timed exit, both request bits
        cyc(1, 8'h03, 0, 0, 0, 0);
        expect_state("R6 pd priority entry", 8'h03, 0, 0, 0);
        cyc(0, 8'h00, 0, 0, 0, 0);
        cyc(0, 8'h00, 0, 0, 0, 0);
        expect_state("R6 pd persists", 8'h03, 0, 0, 0);
        cyc(0, 8'h00, 1, 0, 0, 0);
        expect_state("R7 wake by irq", 8'h03, 1, 0, 1);
        for (int i = 1; i < 16; i++) begin
            cyc(0, 8'h00, 0, 0, 0, 0);
            expect_state("R8 restart held", 8'h03, 1, 0, 1);
        end
        cyc(0, 8'h00, 0, 0, 0, 0);
        expect_state("R8 timed release", 8'h00, 1, 1, 0);

        // Power-down, external exit
        cyc(1, 8'h20, 0, 0, 0, 0);
        expect_state("R3 ext mode", 8'h20, 1, 1, 0);
        cyc(1, 8'h22, 0, 0, 0, 0);
        expect_state("R6 pd entry ext", 8'h22, 0, 0, 0);
        cyc(0, 8'h00, 0, 1, 0, 0);
        expect_state("R7 wake by hold", 8'h22, 1, 0, 1);
        for (int i = 0; i < 20; i++) begin
            cyc(0, 8'h00, 0, 1, 0, 0);
            expect_state("R9 held by pin", 8'h22, 1, 0, 1);
        end
        cyc(0, 8'h00, 0, 0, 0, 0);
        expect_state("R9 pin release", 8'h20, 1, 1, 0);

        cyc(0, 8'h00, 0, 0, 0, 0);
        @(negedge clk);
        #1;
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule